// File: doc/BRIEF.md
# Packed SIMD Saturating Media ALU

This block is a single-cycle execution unit for media kernels. It takes two 32-bit source operands and a 5-bit operation code. Depending on the operation it reads each operand as one 32-bit word, as two 16-bit halfwords, or as four bytes. It returns one 32-bit result in which every lane is clipped to that lane's range; no lane ever wraps. Lane 0 always occupies the least significant bits. Halfword lane 1 is bits [31:16], and byte lane k is bits [8k+7:8k].

The operations cover three groups. The first is saturating arithmetic: add, subtract, multiply and absolute value. The second is lane shaping: clipping and arithmetic shift. The third is video-style reductions: sums of products and byte sums of absolute differences. There are also bytewise min, max and average. One operation mixes signedness inside a lane: an unsigned byte plus a signed byte, clipped to an unsigned byte.

The interface is a valid-qualified request. The result and its valid flag come from one output register, loaded on the clock edge that accepts the request. There is no state machine: the only state is the output register, which either loads or holds.

Top module: `media_simd_alu`

## Requirements
- R1: On the clock edge where in_valid is 1, out_valid becomes 1 and result takes the value of that request. On an edge where in_valid is 0, out_valid becomes 0 and result keeps its value. After reset both are 0.
- R2: Op 0 is signed 32-bit add and op 1 is unsigned 32-bit add. Op 2 is signed 32-bit subtract and op 3 is unsigned 32-bit subtract. Each saturates to its own range: signed results to 0x80000000..0x7FFFFFFF, unsigned results to 0..0xFFFFFFFF.
- R3: Op 4 is signed 32-bit multiply and op 5 is unsigned 32-bit multiply. The full product is clipped to the signed or unsigned 32-bit range.
- R4: Op 6 is the signed 32-bit absolute value; 0x80000000 gives 0x7FFFFFFF. Op 10 applies the same rule to each signed halfword, so 0x8000 gives 0x7FFF.
- R5: Ops 7, 8 and 9 are per-halfword signed add, subtract and multiply. Each lane result is clipped to -32768..32767.
- R6: Op 11 shifts each halfword of operand A right arithmetically. The shift amount is src_b[3:0], in the range 0..15, and the same amount applies to both lanes.
- R7: Ops 12 and 13 clip each halfword of A against a bound taken from the same lane of B. A negative bound counts as 0. Op 12 clamps the signed lane to -bound..+bound. Op 13 clamps it to 0..bound.
- R8: Op 14 adds each unsigned byte of A to the signed byte of B in the same lane. The sum is computed at full precision and then clipped to 0..255.
- R9: Op 15 gives the unsigned maximum of each byte pair and op 16 the unsigned minimum, each lane independently.
- R10: Op 17 gives, per byte lane, the unsigned average (a + b + 1) >> 1.
- R11: Op 18 returns the unsigned 32-bit sum of |a - b| over the four byte lanes, with bytes taken as unsigned. Op 19 returns the same sum with bytes taken as signed.
- R12: Op 20 returns the sum of the two signed halfword products, clipped to the signed 32-bit range. Op 21 returns the sum of the two unsigned halfword products, clipped to the unsigned 32-bit range.
- R13: Ops 22, 23 and 24 return the 32-bit sum of the four byte products. Op 22 multiplies signed by signed, op 23 multiplies signed A by unsigned B, and op 24 multiplies unsigned by unsigned.
- R14: Op codes 25 to 31 produce a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request qualifier |
| op | input | 5 | Operation code |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 32 | Registered lane-clipped result |

## Verification
The bench builds the block with WORD_W at its default of 32, the only width the op codes define. At this width every lane boundary is reachable: the word, halfword and byte extremes 0x7F, 0x80, 0xFF, 0x7FFF, 0x8000 and 0x80000000. The bench sweeps all 32 op codes over a cross product of such boundary words, followed by pseudo-random pairs. This drives every clipping branch, the most-negative absolute-value case, the top shift amounts and the undefined codes.

// File: rtl/media_alu_pkg.sv
package media_alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD_S32    = 5'd0,
        OP_ADD_U32    = 5'd1,
        OP_SUB_S32    = 5'd2,
        OP_SUB_U32    = 5'd3,
        OP_MUL_S32    = 5'd4,
        OP_MUL_U32    = 5'd5,
        OP_ABS_S32    = 5'd6,
        OP_ADD_S16X2  = 5'd7,
        OP_SUB_S16X2  = 5'd8,
        OP_MUL_S16X2  = 5'd9,
        OP_ABS_S16X2  = 5'd10,
        OP_ASR_16X2   = 5'd11,
        OP_CLIPS_16X2 = 5'd12,
        OP_CLIPU_16X2 = 5'd13,
        OP_ADDUS_8X4  = 5'd14,
        OP_MAX_U8X4   = 5'd15,
        OP_MIN_U8X4   = 5'd16,
        OP_AVG_U8X4   = 5'd17,
        OP_SAD_U8X4   = 5'd18,
        OP_SAD_S8X4   = 5'd19,
        OP_DOT_S16X2  = 5'd20,
        OP_DOT_U16X2  = 5'd21,
        OP_DOT_SS8X4  = 5'd22,
        OP_DOT_SU8X4  = 5'd23,
        OP_DOT_UU8X4  = 5'd24
    } alu_op_e;

endpackage

// File: rtl/media_word_unit.sv
module media_word_unit
    import media_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [4:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         hit,
    output logic [W-1:0] res
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0]             s_add, s_sub, u_add, u_sub;
    logic signed [2*W-1:0]  s_mul;
    logic [2*W-1:0]         u_mul;
    logic                   s_mul_fits;

    assign s_add = (W+1)'($signed(a)) + (W+1)'($signed(b));
    assign s_sub = (W+1)'($signed(a)) - (W+1)'($signed(b));
    assign u_add = (W+1)'(a) + (W+1)'(b);
    assign u_sub = (W+1)'(a) - (W+1)'(b);
    assign s_mul = (2*W)'($signed(a)) * (2*W)'($signed(b));
    assign u_mul = (2*W)'(a) * (2*W)'(b);
    assign s_mul_fits = (&s_mul[2*W-1:W-1]) | ~(|s_mul[2*W-1:W-1]);

    always_comb begin
        hit = 1'b1;
        res = '0;
        case (op)
            OP_ADD_S32: res = (s_add[W] != s_add[W-1]) ? (s_add[W] ? SMIN : SMAX) : s_add[W-1:0];
            OP_ADD_U32: res = u_add[W] ? '1 : u_add[W-1:0];
            OP_SUB_S32: res = (s_sub[W] != s_sub[W-1]) ? (s_sub[W] ? SMIN : SMAX) : s_sub[W-1:0];
            OP_SUB_U32: res = u_sub[W] ? '0 : u_sub[W-1:0];
            OP_MUL_S32: res = s_mul_fits ? s_mul[W-1:0] : (s_mul[2*W-1] ? SMIN : SMAX);
            OP_MUL_U32: res = (|u_mul[2*W-1:W]) ? '1 : u_mul[W-1:0];
            OP_ABS_S32: res = (a == SMIN) ? SMAX : (a[W-1] ? -a : a);
            default:    hit = 1'b0;
        endcase
    end

    AST_UADD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADD_U32) |-> (res >= a && res >= b)); // R2
    AST_USUB_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SUB_U32) |-> (res <= a)); // R2

endmodule

// File: rtl/media_half_unit.sv
module media_half_unit
    import media_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [4:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         hit,
    output logic [W-1:0] res
);
    localparam int H     = W / 2;
    localparam int LANES = 2;
    localparam int SHW   = $clog2(H);
    localparam logic [H-1:0] HMAX = {1'b0, {(H-1){1'b1}}};
    localparam logic [H-1:0] HMIN = {1'b1, {(H-1){1'b0}}};
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [H-1:0]          r_add [LANES];
    logic [H-1:0]          r_sub [LANES];
    logic [H-1:0]          r_mul [LANES];
    logic [H-1:0]          r_abs [LANES];
    logic [H-1:0]          r_asr [LANES];
    logic [H-1:0]          r_cls [LANES];
    logic [H-1:0]          r_clu [LANES];
    logic [H-1:0]          bound [LANES];
    logic signed [2*H-1:0] p_s   [LANES];
    logic [2*H-1:0]        p_u   [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [H-1:0]   la, lb, nbnd;
        logic [H:0]     sum, dif;
        logic           mul_fits;
        assign la  = a[i*H +: H];
        assign lb  = b[i*H +: H];
        assign sum = (H+1)'($signed(la)) + (H+1)'($signed(lb));
        assign dif = (H+1)'($signed(la)) - (H+1)'($signed(lb));
        assign p_s[i] = (2*H)'($signed(la)) * (2*H)'($signed(lb));
        assign p_u[i] = (2*H)'(la) * (2*H)'(lb);
        assign mul_fits = (&p_s[i][2*H-1:H-1]) | ~(|p_s[i][2*H-1:H-1]);

        assign r_add[i] = (sum[H] != sum[H-1]) ? (sum[H] ? HMIN : HMAX) : sum[H-1:0];
        assign r_sub[i] = (dif[H] != dif[H-1]) ? (dif[H] ? HMIN : HMAX) : dif[H-1:0];
        assign r_mul[i] = mul_fits ? p_s[i][H-1:0] : (p_s[i][2*H-1] ? HMIN : HMAX);
        assign r_abs[i] = (la == HMIN) ? HMAX : (la[H-1] ? -la : la);
        assign r_asr[i] = $signed(la) >>> b[SHW-1:0];

        assign bound[i] = lb[H-1] ? '0 : lb;
        assign nbnd     = -bound[i];
        assign r_cls[i] = ($signed(la) > $signed(bound[i])) ? bound[i] :
                          ($signed(la) < $signed(nbnd))     ? nbnd     : la;
        assign r_clu[i] = la[H-1] ? '0 : ((la > bound[i]) ? bound[i] : la);

        AST_CLIPU_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_CLIPU_16X2) |-> (res[i*H +: H] <= bound[i])); // R7
        AST_HABS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_ABS_S16X2) |-> !res[i*H + H - 1]); // R4
    end

    logic signed [W:0] dot_s;
    logic [W:0]        dot_u;
    assign dot_s = (W+1)'(p_s[0]) + (W+1)'(p_s[1]);
    assign dot_u = (W+1)'(p_u[0]) + (W+1)'(p_u[1]);

    always_comb begin
        hit = 1'b1;
        res = '0;
        case (op)
            OP_ADD_S16X2:  for (int i = 0; i < LANES; i++) res[i*H +: H] = r_add[i];
            OP_SUB_S16X2:  for (int i = 0; i < LANES; i++) res[i*H +: H] = r_sub[i];
            OP_MUL_S16X2:  for (int i = 0; i < LANES; i++) res[i*H +: H] = r_mul[i];
            OP_ABS_S16X2:  for (int i = 0; i < LANES; i++) res[i*H +: H] = r_abs[i];
            OP_ASR_16X2:   for (int i = 0; i < LANES; i++) res[i*H +: H] = r_asr[i];
            OP_CLIPS_16X2: for (int i = 0; i < LANES; i++) res[i*H +: H] = r_cls[i];
            OP_CLIPU_16X2: for (int i = 0; i < LANES; i++) res[i*H +: H] = r_clu[i];
            OP_DOT_S16X2:  res = (dot_s[W] != dot_s[W-1]) ? (dot_s[W] ? SMIN : SMAX) : dot_s[W-1:0];
            OP_DOT_U16X2:  res = dot_u[W] ? '1 : dot_u[W-1:0];
            default:       hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/media_byte_unit.sv
module media_byte_unit
    import media_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [4:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         hit,
    output logic [W-1:0] res
);
    localparam int B     = W / 4;
    localparam int LANES = 4;
    localparam logic [W-1:0] SAD_CEIL = W'(LANES * ((1 << B) - 1));

    logic [B-1:0]          r_mx  [LANES];
    logic [B-1:0]          r_max [LANES];
    logic [B-1:0]          r_min [LANES];
    logic [B-1:0]          r_avg [LANES];
    logic [B:0]            ad_u  [LANES];
    logic [B:0]            ad_s  [LANES];
    logic signed [2*B-1:0] p_ss  [LANES];
    logic signed [2*B:0]   p_su  [LANES];
    logic [2*B-1:0]        p_uu  [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [B-1:0]        la, lb;
        logic signed [B+1:0] mix;
        logic signed [B:0]   sdif;
        assign la   = a[i*B +: B];
        assign lb   = b[i*B +: B];
        assign mix  = $signed((B+2)'(la)) + (B+2)'($signed(lb));
        assign r_mx[i]  = mix[B+1] ? '0 : (mix[B] ? '1 : mix[B-1:0]);
        assign r_max[i] = (la > lb) ? la : lb;
        assign r_min[i] = (la > lb) ? lb : la;
        assign r_avg[i] = B'(((B+1)'(la) + (B+1)'(lb) + (B+1)'(1)) >> 1);
        assign ad_u[i]  = (la > lb) ? (B+1)'(la - lb) : (B+1)'(lb - la);
        assign sdif     = (B+1)'($signed(la)) - (B+1)'($signed(lb));
        assign ad_s[i]  = sdif[B] ? -sdif : sdif;
        assign p_ss[i]  = (2*B)'($signed(la)) * (2*B)'($signed(lb));
        assign p_su[i]  = (2*B+1)'($signed(la)) * $signed((2*B+1)'(lb));
        assign p_uu[i]  = (2*B)'(la) * (2*B)'(lb);

        AST_AVG_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
            (op == OP_AVG_U8X4) |-> (res[i*B +: B] >= r_min[i] && res[i*B +: B] <= r_max[i])); // R10
    end

    logic [W-1:0] sad_u, sad_s, dot_ss, dot_su, dot_uu;
    always_comb begin
        sad_u  = '0;
        sad_s  = '0;
        dot_ss = '0;
        dot_su = '0;
        dot_uu = '0;
        for (int i = 0; i < LANES; i++) begin
            sad_u  = sad_u  + W'(ad_u[i]);
            sad_s  = sad_s  + W'(ad_s[i]);
            dot_ss = dot_ss + W'(p_ss[i]);
            dot_su = dot_su + W'(p_su[i]);
            dot_uu = dot_uu + W'(p_uu[i]);
        end
    end

    always_comb begin
        hit = 1'b1;
        res = '0;
        case (op)
            OP_ADDUS_8X4: for (int i = 0; i < LANES; i++) res[i*B +: B] = r_mx[i];
            OP_MAX_U8X4:  for (int i = 0; i < LANES; i++) res[i*B +: B] = r_max[i];
            OP_MIN_U8X4:  for (int i = 0; i < LANES; i++) res[i*B +: B] = r_min[i];
            OP_AVG_U8X4:  for (int i = 0; i < LANES; i++) res[i*B +: B] = r_avg[i];
            OP_SAD_U8X4:  res = sad_u;
            OP_SAD_S8X4:  res = sad_s;
            OP_DOT_SS8X4: res = dot_ss;
            OP_DOT_SU8X4: res = dot_su;
            OP_DOT_UU8X4: res = dot_uu;
            default:      hit = 1'b0;
        endcase
    end

    AST_SAD_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SAD_U8X4 || op == OP_SAD_S8X4) |-> (res <= SAD_CEIL)); // R11

endmodule

// File: rtl/media_simd_alu.sv
module media_simd_alu
    import media_alu_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [4:0]        op,
    input  logic [WORD_W-1:0] src_a,
    input  logic [WORD_W-1:0] src_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] result
);
    logic              w_hit, h_hit, b_hit;
    logic [WORD_W-1:0] w_res, h_res, b_res, res_d;

    media_word_unit #(.W(WORD_W)) u_word (
        .clk(clk), .rst_n(rst_n), .op(op), .a(src_a), .b(src_b), .hit(w_hit), .res(w_res)
    );
    media_half_unit #(.W(WORD_W)) u_half (
        .clk(clk), .rst_n(rst_n), .op(op), .a(src_a), .b(src_b), .hit(h_hit), .res(h_res)
    );
    media_byte_unit #(.W(WORD_W)) u_byte (
        .clk(clk), .rst_n(rst_n), .op(op), .a(src_a), .b(src_b), .hit(b_hit), .res(b_res)
    );

    always_comb begin
        unique case ({w_hit, h_hit, b_hit})
            3'b100:  res_d = w_res;
            3'b010:  res_d = h_res;
            3'b001:  res_d = b_res;
            default: res_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= res_d;
        end
    end

    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({w_hit, h_hit, b_hit}) <= 1); // R14
    AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R1
    AST_ABS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_ABS_S32) |=> !result[WORD_W-1]); // R4
    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > OP_DOT_UU8X4) |=> (result == '0)); // R14

endmodule

// File: tb/tb_media_simd_alu.sv
`timescale 1ns/1ps
module tb_media_simd_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        out_valid;
    logic [31:0] result;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    media_simd_alu dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result)
    );

    function automatic longint lu(logic [31:0] x, int w, int i);
        longint m = (longint'(1) << w) - 1;
        return (longint'(x) >> (i * w)) & m;
    endfunction

    function automatic longint ls(logic [31:0] x, int w, int i);
        longint u = lu(x, w, i);
        return (u >= (longint'(1) << (w - 1))) ? u - (longint'(1) << w) : u;
    endfunction

    function automatic longint clampv(longint v, longint lo, longint hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic longint absv(longint v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic logic [31:0] model(logic [4:0] o, logic [31:0] a, logic [31:0] b);
        longint smx = (longint'(1) << 31) - 1;
        longint smn = -(longint'(1) << 31);
        longint umx = (longint'(1) << 32) - 1;
        longint acc = 0;
        logic [31:0] r = '0;
        case (o)
            5'd0: r = 32'(clampv(ls(a,32,0) + ls(b,32,0), smn, smx));
            5'd1: r = 32'(clampv(lu(a,32,0) + lu(b,32,0), 0, umx));
            5'd2: r = 32'(clampv(ls(a,32,0) - ls(b,32,0), smn, smx));
            5'd3: r = 32'(clampv(lu(a,32,0) - lu(b,32,0), 0, umx));
            5'd4: r = 32'(clampv(ls(a,32,0) * ls(b,32,0), smn, smx));
            5'd5: begin
                if (lu(a,32,0) != 0 && lu(b,32,0) > umx / lu(a,32,0)) r = '1;
                else r = 32'(lu(a,32,0) * lu(b,32,0));
            end
            5'd6: r = 32'(clampv(absv(ls(a,32,0)), 0, smx));
            5'd7, 5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13: begin
                for (int i = 0; i < 2; i++) begin
                    longint x = ls(a,16,i);
                    longint y = ls(b,16,i);
                    longint bnd = (y < 0) ? 0 : y;
                    longint v = 0;
                    case (o)
                        5'd7:  v = clampv(x + y, -32768, 32767);
                        5'd8:  v = clampv(x - y, -32768, 32767);
                        5'd9:  v = clampv(x * y, -32768, 32767);
                        5'd10: v = clampv(absv(x), 0, 32767);
                        5'd11: v = x >>> lu(b,4,0);
                        5'd12: v = clampv(x, -bnd, bnd);
                        default: v = clampv(x, 0, bnd);
                    endcase
                    r[i*16 +: 16] = 16'(v);
                end
            end
            5'd14, 5'd15, 5'd16, 5'd17: begin
                for (int i = 0; i < 4; i++) begin
                    longint x = lu(a,8,i);
                    longint y = lu(b,8,i);
                    longint v = 0;
                    case (o)
                        5'd14: v = clampv(x + ls(b,8,i), 0, 255);
                        5'd15: v = (x > y) ? x : y;
                        5'd16: v = (x < y) ? x : y;
                        default: v = (x + y + 1) / 2;
                    endcase
                    r[i*8 +: 8] = 8'(v);
                end
            end
            5'd18, 5'd19, 5'd22, 5'd23, 5'd24: begin
                for (int i = 0; i < 4; i++) begin
                    case (o)
                        5'd18: acc += absv(lu(a,8,i) - lu(b,8,i));
                        5'd19: acc += absv(ls(a,8,i) - ls(b,8,i));
                        5'd22: acc += ls(a,8,i) * ls(b,8,i);
                        5'd23: acc += ls(a,8,i) * lu(b,8,i);
                        default: acc += lu(a,8,i) * lu(b,8,i);
                    endcase
                end
                r = 32'(acc);
            end
            5'd20: r = 32'(clampv(ls(a,16,0)*ls(b,16,0) + ls(a,16,1)*ls(b,16,1), smn, smx));
            5'd21: r = 32'(clampv(lu(a,16,0)*lu(b,16,0) + lu(a,16,1)*lu(b,16,1), 0, umx));
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string req_of(logic [4:0] o);
        case (o)
            5'd0, 5'd1, 5'd2, 5'd3:     return "R2";
            5'd4, 5'd5:                 return "R3";
            5'd6, 5'd10:                return "R4";
            5'd7, 5'd8, 5'd9:           return "R5";
            5'd11:                      return "R6";
            5'd12, 5'd13:               return "R7";
            5'd14:                      return "R8";
            5'd15, 5'd16:               return "R9";
            5'd17:                      return "R10";
            5'd18, 5'd19:               return "R11";
            5'd20, 5'd21:               return "R12";
            5'd22, 5'd23, 5'd24:        return "R13";
            default:                    return "R14";
        endcase
    endfunction

    function automatic logic [31:0] pat(int i);
        case (i)
            0:  return 32'h0000_0000;
            1:  return 32'h0000_0001;
            2:  return 32'hFFFF_FFFF;
            3:  return 32'h7FFF_FFFF;
            4:  return 32'h8000_0000;
            5:  return 32'h8000_8000;
            6:  return 32'h7FFF_7FFF;
            7:  return 32'h807F_7F80;
            8:  return 32'h01FF_80FE;
            9:  return 32'h1234_5678;
            10: return 32'hFEDC_BA98;
            11: return 32'h0000_000F;
            12: return 32'h0001_FFFF;
            default: return 32'h00FF_FF00;
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run(logic [4:0] o, logic [31:0] a, logic [31:0] b);
        logic [31:0] exp;
        @(negedge clk);
        in_valid = 1'b1; op = o; src_a = a; src_b = b;
        exp = model(o, a, b);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1, "R1", "out_valid after request", 32'(out_valid), 32'd1);
        check(result === exp, req_of(o), $sformatf("op %0d a=%h b=%h", o, a, b), result, exp);
    endtask

    initial begin
        logic [31:0] seed = 32'h1ACE_B00C;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1", "reset out_valid", 32'(out_valid), 32'd0);
        check(result === 32'd0, "R1", "reset result", result, 32'd0);
        rst_n = 1'b1;
        for (int o = 0; o < 32; o++) begin
            for (int i = 0; i < 14; i++)
                for (int j = 0; j < 14; j++)
                    run(5'(o), pat(i), pat(j));
            for (int k = 0; k < 100; k++) begin
                logic [31:0] ra, rb;
                seed = seed * 32'd1664525 + 32'd1013904223; ra = seed;
                seed = seed * 32'd1664525 + 32'd1013904223; rb = seed;
                run(5'(o), ra, rb);
            end
            // R1: idle cycle with changed inputs must leave result untouched
            held = result;
            @(negedge clk);
            src_a = ~src_a; src_b = src_b ^ 32'h5A5A_A5A5; op = 5'(o + 1);
            @(negedge clk);
            check(out_valid === 1'b0, "R1", "idle out_valid", 32'(out_valid), 32'd0);
            check(result === held, "R1", "idle hold", result, held);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule